// File: doc/BRIEF.md
# Radius-2 Stencil Window Line Buffer

This unit sits between a row-major stream of grid cells and a plate-dynamics arithmetic core. Each incoming cell record packs four state words: displacement at the current step, displacement at the previous step, velocity at the current step and velocity at the previous step. The unit emits, for every grid cell in raster order, the thirteen current-step displacement values of a radius-2 stencil: the centre, two cells up, down, left and right, and the four nearest diagonals. It also emits the full four-word record of the centre cell for the time integrator.

The unit serves a single processing column. It keeps four lines on chip for a five-row window, and the arriving cell goes straight into the newest row of the window without passing through a line store. Only the two most recent lines hold full records. The two older lines hold displacement only, because only the centre row needs the whole record.

Free plate edges are zero-flux. An out-of-grid neighbour takes the value of its mirror image across the edge. Suspension cells sit at the middle of each of the four edges, and the unit raises a per-cell flag there so that the core can pin their update to zero. To keep the window complete, the unit inserts two padding steps at the end of each row and two padding rows at the end of each frame. During these steps it does not accept input, and they let the last rows and columns drain.

Top module: `stencil_window_unit`

## Requirements
- R1: After reset, `out_valid` and `out_anchor` are low and `in_ready` is high.
- R2: The unit scans (GRID_H+2)×(GRID_W+2) positions per frame. `in_ready` is high exactly at grid positions (row < GRID_H, column < GRID_W). Each padding position advances in one cycle with `in_ready` low, so every frame has (GRID_H+2)(GRID_W+2) − GRID_H·GRID_W padding steps.
- R3: A scan step happens on a clock edge where `in_ready` is low, or where `in_ready` and `in_valid` are both high. A step at scan position (r, c) with r ≥ 2 and c ≥ 2 makes `out_valid` high in the following cycle for cell (r−2, c−2). No other cycle has `out_valid` high, so each frame yields exactly GRID_H·GRID_W outputs in raster order.
- R4: `out_win` is packed as 13 slots of STATE_W bits, slot s at bits [s·STATE_W +: STATE_W]. The slots hold the offsets (row, column): 0 (0,0); 1 (−1,0); 2 (−2,0); 3 (+1,0); 4 (+2,0); 5 (0,−1); 6 (0,−2); 7 (0,+1); 8 (0,+2); 9 (−1,−1); 10 (−1,+1); 11 (+1,−1); 12 (+1,+1). Each slot holds state word 0 of that neighbour.
- R5: A neighbour row outside the grid is replaced by its mirror image: row −k becomes row k, and row GRID_H−1+k becomes row GRID_H−1−k.
- R6: A neighbour column outside the grid is mirrored the same way across the left and right edges.
- R7: `out_centre` is the centre cell's full record. State word w sits at bits [w·STATE_W +: STATE_W], with w = 0 displacement now, 1 displacement previous, 2 velocity now and 3 velocity previous.
- R8: `out_anchor` is high, together with `out_valid`, exactly for suspension cells. These are cells in row 0 or row GRID_H−1 with |column − GRID_W/2| ≤ ANCHOR_HALF, and cells in column 0 or column GRID_W−1 with |row − GRID_H/2| ≤ ANCHOR_HALF.
- R9: While `in_ready` is high and `in_valid` is low, the scan position holds and no output is produced in the next cycle.
- R10: Consecutive frames are independent: values from a previous frame never appear in the window or centre record of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming cell record present |
| in_ready | output | 1 | Unit is at a grid position and will take a cell |
| in_cell | input | 4·STATE_W | Packed cell record, word order as in R7 |
| out_valid | output | 1 | Window and centre record valid this cycle |
| out_win | output | 13·STATE_W | Stencil neighbourhood, slot order as in R4 |
| out_centre | output | 4·STATE_W | Centre cell record |
| out_anchor | output | 1 | Centre cell is a suspension point |

## Verification
The bench builds the unit on a 6-column, 5-row grid with 16-bit state words and a one-cell suspension span. On that grid every row except the middle one lies within two cells of a top or bottom edge. Every column lies within two cells of a side edge except the two middle ones. So all mirror combinations, the four corners and all four suspension cells occur in each frame. The bench runs two consecutive frames with distinct cell values and checks every emitted cell against a reflected-index model. The second frame inserts periodic gaps in `in_valid` to exercise stalls.

// File: rtl/stencil_window_pkg.sv
package stencil_window_pkg;

  localparam int WIN_SPAN  = 5;   // rows and columns of the stencil window
  localparam int NUM_SLOTS = 13;  // stencil points emitted per cell
  localparam int NUM_LINES = 4;   // on-chip lines for a five-row window
  localparam int REC_WORDS = 4;   // state words per cell record

  // Offset (in -2..2) of the cell that stands in for pos+d on an axis of
  // n cells, mirroring across either edge.
  function automatic int mirror_off(input int pos, input int d, input int n);
    int t;
    int r;
    t = pos + d;
    if (t < 0)          r = -t - pos;
    else if (t > n - 1) r = 2 * (n - 1) - t - pos;
    else                r = d;
    if (r < -2) r = -2;
    if (r > 2)  r = 2;
    return r;
  endfunction

endpackage

// File: rtl/sw_line_store.sv
module sw_line_store #(
  parameter int DEPTH  = 512,
  parameter int WORD_W = 64,
  parameter int AW     = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  // read-before-write: old entry leaves as the new one lands
  assign rdata = mem_q[addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[addr] <= wdata;
  end

endmodule

// File: rtl/sw_scan.sv
module sw_scan #(
  parameter int GRID_W = 512,
  parameter int GRID_H = 512,
  parameter int CW     = 10,
  parameter int RW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          step,
  output logic [RW-1:0] scan_row,
  output logic [CW-1:0] scan_col
);

  localparam logic [CW-1:0] LAST_COL = CW'(GRID_W + 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(GRID_H + 1);

  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;

  assign in_ready = (row_q < RW'(GRID_H)) && (col_q < CW'(GRID_W));
  assign step     = in_ready ? in_valid : 1'b1;
  assign scan_row = row_q;
  assign scan_col = col_q;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (step) begin
      if (col_q == LAST_COL) begin
        col_d = '0;
        row_d = (row_q == LAST_ROW) ? '0 : row_q + RW'(1);
      end else begin
        col_d = col_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

endmodule

// File: rtl/sw_window.sv
module sw_window
  import stencil_window_pkg::*;
#(
  parameter int STATE_W     = 36,
  parameter int GRID_W      = 512,
  parameter int GRID_H      = 512,
  parameter int ANCHOR_HALF = 1,
  parameter int CW          = 10,
  parameter int RW          = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           step,
  input  logic [RW-1:0]                  scan_row,
  input  logic [CW-1:0]                  scan_col,
  input  logic [STATE_W-1:0]             col_in [WIN_SPAN],
  input  logic [REC_WORDS*STATE_W-1:0]   mid_rec,
  output logic                           out_valid,
  output logic [NUM_SLOTS*STATE_W-1:0]   out_win,
  output logic [REC_WORDS*STATE_W-1:0]   out_centre,
  output logic                           out_anchor
);

  localparam int REC_W = REC_WORDS * STATE_W;

  logic [STATE_W-1:0] vcol [WIN_SPAN];
  logic [STATE_W-1:0] sreg_q [WIN_SPAN][WIN_SPAN];   // [column age][row]
  logic [REC_W-1:0]   rec_q  [3];
  logic [STATE_W-1:0] slot   [NUM_SLOTS];
  logic               valid_q, valid_d;
  logic [RW-1:0]      rc_q;
  logic [CW-1:0]      cc_q;

  // Row mirroring applied as each column enters the window
  always_comb begin
    int rc;
    rc = int'(scan_row) - 2;
    for (int k = 0; k < WIN_SPAN; k++) begin
      if (scan_row >= RW'(2)) vcol[k] = col_in[2 + mirror_off(rc, k - 2, GRID_H)];
      else                    vcol[k] = col_in[k];
    end
  end

  assign valid_d = step && (scan_row >= RW'(2)) && (scan_col >= CW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (step) begin
      for (int k = 0; k < WIN_SPAN; k++) begin
        sreg_q[0][k] <= vcol[k];
        for (int j = 1; j < WIN_SPAN; j++) sreg_q[j][k] <= sreg_q[j-1][k];
      end
      rec_q[0] <= mid_rec;
      rec_q[1] <= rec_q[0];
      rec_q[2] <= rec_q[1];
      rc_q     <= scan_row - RW'(2);
      cc_q     <= scan_col - CW'(2);
    end
  end

  // Column mirroring selects which stored column serves each offset
  always_comb begin
    int cc, rc, jl1, jl2, jr1, jr2;
    cc  = int'(cc_q);
    rc  = int'(rc_q);
    jl1 = 2 - mirror_off(cc, -1, GRID_W);
    jl2 = 2 - mirror_off(cc, -2, GRID_W);
    jr1 = 2 - mirror_off(cc,  1, GRID_W);
    jr2 = 2 - mirror_off(cc,  2, GRID_W);
    slot[0]  = sreg_q[2][2];
    slot[1]  = sreg_q[2][1];
    slot[2]  = sreg_q[2][0];
    slot[3]  = sreg_q[2][3];
    slot[4]  = sreg_q[2][4];
    slot[5]  = sreg_q[jl1][2];
    slot[6]  = sreg_q[jl2][2];
    slot[7]  = sreg_q[jr1][2];
    slot[8]  = sreg_q[jr2][2];
    slot[9]  = sreg_q[jl1][1];
    slot[10] = sreg_q[jr1][1];
    slot[11] = sreg_q[jl1][3];
    slot[12] = sreg_q[jr1][3];
    out_anchor = valid_q &&
      (((rc == 0 || rc == GRID_H - 1) &&
        (cc - GRID_W / 2 <= ANCHOR_HALF) && (GRID_W / 2 - cc <= ANCHOR_HALF)) ||
       ((cc == 0 || cc == GRID_W - 1) &&
        (rc - GRID_H / 2 <= ANCHOR_HALF) && (GRID_H / 2 - rc <= ANCHOR_HALF)));
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_pack
    assign out_win[s*STATE_W +: STATE_W] = slot[s];
  end

  assign out_valid  = valid_q;
  assign out_centre = rec_q[2];

endmodule

// File: rtl/stencil_window_unit.sv
module stencil_window_unit
  import stencil_window_pkg::*;
#(
  parameter int STATE_W     = 36,
  parameter int GRID_W      = 512,
  parameter int GRID_H      = 512,
  parameter int ANCHOR_HALF = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [REC_WORDS*STATE_W-1:0]   in_cell,
  output logic                           out_valid,
  output logic [NUM_SLOTS*STATE_W-1:0]   out_win,
  output logic [REC_WORDS*STATE_W-1:0]   out_centre,
  output logic                           out_anchor
);

  localparam int REC_W = REC_WORDS * STATE_W;
  localparam int AW    = $clog2(GRID_W);
  localparam int CW    = $clog2(GRID_W + 2);
  localparam int RW    = $clog2(GRID_H + 2);

  logic               rst_meta_q, rst_core_q;
  logic               step;
  logic [RW-1:0]      scan_row;
  logic [CW-1:0]      scan_col;
  logic               line_we;
  logic [AW-1:0]      line_addr;
  logic [REC_W-1:0]   cell_w;
  logic [REC_W-1:0]   rec_rd  [2];   // rows r-1, r-2 (full records)
  logic [STATE_W-1:0] disp_rd [2];   // rows r-3, r-4 (displacement only)
  logic [STATE_W-1:0] col_in  [WIN_SPAN];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_q <= rst_meta_q;
    end
  end

  sw_scan #(.GRID_W(GRID_W), .GRID_H(GRID_H), .CW(CW), .RW(RW)) u_scan (
    .clk(clk), .rst_n(rst_core_q), .in_valid(in_valid), .in_ready(in_ready),
    .step(step), .scan_row(scan_row), .scan_col(scan_col)
  );

  assign cell_w    = in_ready ? in_cell : '0;
  assign line_we   = step && (scan_col < CW'(GRID_W));
  assign line_addr = (scan_col < CW'(GRID_W)) ? scan_col[AW-1:0] : '0;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    if (g == 0) begin : g_full_head
      sw_line_store #(.DEPTH(GRID_W), .WORD_W(REC_W), .AW(AW)) u_line (
        .clk(clk), .wr_en(line_we), .addr(line_addr), .wdata(cell_w), .rdata(rec_rd[0]));
    end else if (g == 1) begin : g_full_mid
      sw_line_store #(.DEPTH(GRID_W), .WORD_W(REC_W), .AW(AW)) u_line (
        .clk(clk), .wr_en(line_we), .addr(line_addr), .wdata(rec_rd[0]), .rdata(rec_rd[1]));
    end else if (g == 2) begin : g_disp_head
      sw_line_store #(.DEPTH(GRID_W), .WORD_W(STATE_W), .AW(AW)) u_line (
        .clk(clk), .wr_en(line_we), .addr(line_addr),
        .wdata(rec_rd[1][STATE_W-1:0]), .rdata(disp_rd[0]));
    end else begin : g_disp_tail
      sw_line_store #(.DEPTH(GRID_W), .WORD_W(STATE_W), .AW(AW)) u_line (
        .clk(clk), .wr_en(line_we), .addr(line_addr), .wdata(disp_rd[0]), .rdata(disp_rd[1]));
    end
  end

  // newest row enters the window straight from the input
  assign col_in[4] = cell_w[STATE_W-1:0];
  assign col_in[3] = rec_rd[0][STATE_W-1:0];
  assign col_in[2] = rec_rd[1][STATE_W-1:0];
  assign col_in[1] = disp_rd[0];
  assign col_in[0] = disp_rd[1];

  sw_window #(
    .STATE_W(STATE_W), .GRID_W(GRID_W), .GRID_H(GRID_H),
    .ANCHOR_HALF(ANCHOR_HALF), .CW(CW), .RW(RW)
  ) u_window (
    .clk(clk), .rst_n(rst_core_q), .step(step), .scan_row(scan_row), .scan_col(scan_col),
    .col_in(col_in), .mid_rec(rec_rd[1]), .out_valid(out_valid), .out_win(out_win),
    .out_centre(out_centre), .out_anchor(out_anchor)
  );

endmodule

// File: rtl/sw_window_checker.sv
module sw_window_checker
  import stencil_window_pkg::*;
#(
  parameter int STATE_W = 36,
  parameter int GRID_W  = 512,
  parameter int GRID_H  = 512
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         in_ready,
  input logic                         out_valid,
  input logic [NUM_SLOTS*STATE_W-1:0] out_win,
  input logic [REC_WORDS*STATE_W-1:0] out_centre,
  input logic                         out_anchor
);

  localparam int PAD_MAX = 2 * GRID_W + 6;
  localparam int PW      = $clog2(PAD_MAX + 2) + 1;

  logic [PW-1:0] pad_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pad_run_q <= '0;
    else if (in_ready)  pad_run_q <= '0;
    else if (pad_run_q != {PW{1'b1}}) pad_run_q <= pad_run_q + PW'(1);
  end

  AST_OUT_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!in_ready || in_valid));                             // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (in_ready && !out_valid));                   // R9
  AST_PAD_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    pad_run_q <= PW'(PAD_MAX));                                              // R2
  AST_CENTRE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_win[STATE_W-1:0] == out_centre[STATE_W-1:0]));        // R7
  AST_ANCHOR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_anchor |-> out_valid);                                               // R8

endmodule

bind stencil_window_unit sw_window_checker #(
  .STATE_W(STATE_W), .GRID_W(GRID_W), .GRID_H(GRID_H)
) u_sw_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_win(out_win), .out_centre(out_centre),
  .out_anchor(out_anchor)
);

// File: tb/tb_stencil_window_unit.sv
`timescale 1ns/1ps
module tb_stencil_window_unit;

  localparam int SW = 16;
  localparam int GW = 6;
  localparam int GH = 5;
  localparam int AH = 0;
  localparam int CELLS = GW * GH;
  localparam int PADS  = (GW + 2) * (GH + 2) - CELLS;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic           in_ready;
  logic [4*SW-1:0]  in_cell;
  logic           out_valid;
  logic [13*SW-1:0] out_win;
  logic [4*SW-1:0]  out_centre;
  logic           out_anchor;

  int checks;
  int fails;

  stencil_window_unit #(.STATE_W(SW), .GRID_W(GW), .GRID_H(GH), .ANCHOR_HALF(AH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cell(in_cell), .out_valid(out_valid), .out_win(out_win),
    .out_centre(out_centre), .out_anchor(out_anchor)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int cval(int f, int i, int j, int w);
    return f * 4096 + w * 1024 + i * 32 + j + 1;
  endfunction

  function automatic int refl(int i, int n);
    if (i < 0)     return -i;
    if (i > n - 1) return 2 * n - 2 - i;
    return i;
  endfunction

  function automatic int slot_dr(int s);
    case (s)
      1, 9, 10: return -1;
      2:        return -2;
      3, 11, 12: return 1;
      4:        return 2;
      default:  return 0;
    endcase
  endfunction

  function automatic int slot_dc(int s);
    case (s)
      5, 9, 11: return -1;
      6:        return -2;
      7, 10, 12: return 1;
      8:        return 2;
      default:  return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    int mr, mc, fr, cyc, outs, pads, oi, oj, ofr;
    bit exp_ready, drv_v, stp, ev, wrap;
    checks = 0; fails = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_cell = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet outputs, ready for the first cell
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_anchor == 1'b0, "R1 out_anchor", int'(out_anchor), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    mr = 0; mc = 0; fr = 0; cyc = 0; outs = 0; pads = 0; oi = 0; oj = 0; ofr = 0;
    while (fr < 2 && cyc < 4000) begin
      exp_ready = (mr < GH) && (mc < GW);
      drv_v = !(fr == 1 && (cyc % 5) == 2);
      in_valid = drv_v;
      in_cell = exp_ready ? {SW'(cval(fr, mr, mc, 3)), SW'(cval(fr, mr, mc, 2)),
                             SW'(cval(fr, mr, mc, 1)), SW'(cval(fr, mr, mc, 0))} : '0;
      @(negedge clk);
      cyc++;
      stp = exp_ready ? drv_v : 1'b1;
      ev = 1'b0; wrap = 1'b0;
      if (stp) begin
        if (!exp_ready) pads++;
        if (mr >= 2 && mc >= 2) begin
          ev = 1'b1; oi = mr - 2; oj = mc - 2; ofr = fr;
        end
        if (mc == GW + 1) begin
          mc = 0;
          if (mr == GH + 1) begin mr = 0; wrap = 1'b1; end
          else mr++;
        end else mc++;
      end
      if (stp) check(out_valid == ev, "R3 out_valid timing", int'(out_valid), int'(ev));
      else     check(out_valid == 1'b0, "R9 no output while stalled", int'(out_valid), 0);

      if (ev && out_valid) begin
        bit wok; int bad_act, bad_exp; string tag;
        outs++;
        wok = 1'b1; bad_act = 0; bad_exp = 0;
        for (int s = 0; s < 13; s++) begin
          int e, a;
          e = cval(ofr, refl(oi + slot_dr(s), GH), refl(oj + slot_dc(s), GW), 0) & 16'hFFFF;
          a = int'(out_win[s*SW +: SW]);
          if (a != e && wok) begin wok = 1'b0; bad_act = a; bad_exp = e; end
        end
        if (oi < 2 || oi > GH - 3)      tag = "R5 row-mirrored window";
        else if (oj < 2 || oj > GW - 3) tag = "R6 column-mirrored window";
        else                            tag = "R4 interior window";
        if (ofr == 1 && !wok) tag = {tag, " R10"};
        check(wok, tag, bad_act, bad_exp);
        for (int w = 0; w < 4; w++) begin
          int e, a;
          e = cval(ofr, oi, oj, w) & 16'hFFFF;
          a = int'(out_centre[w*SW +: SW]);
          check(a == e, (ofr == 0) ? "R7 centre record" : "R10 centre record", a, e);
        end
        begin
          bit ea;
          ea = ((oi == 0 || oi == GH - 1) && (oj - GW / 2 <= AH) && (GW / 2 - oj <= AH)) ||
               ((oj == 0 || oj == GW - 1) && (oi - GH / 2 <= AH) && (GH / 2 - oi <= AH));
          check(out_anchor == ea, "R8 anchor flag", int'(out_anchor), int'(ea));
        end
      end else if (!ev) begin
        check(out_anchor == 1'b0, "R8 anchor without output", int'(out_anchor), 0);
      end

      check(in_ready == ((mr < GH) && (mc < GW)), "R2 in_ready position",
            int'(in_ready), int'((mr < GH) && (mc < GW)));

      if (wrap) begin
        check(outs == CELLS, "R3 outputs per frame", outs, CELLS);
        check(pads == PADS, "R2 padding steps per frame", pads, PADS);
        outs = 0; pads = 0; fr++;
      end
    end
    in_valid = 1'b0;
    if (fr < 2) begin
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", fr, 2);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule